// File: doc/BRIEF.md
# Snooping Three-State Coherence Line Controller

This block tracks the coherence state of every line held in one private cache that sits on a shared, snooped bus. Local load and store requests come in from the processor side. Transactions observed from other caches come in on a snoop port. The block keeps a small direct-mapped array of tags and line states, and decides for each request whether the processor can be answered at once or whether a bus command is needed. The possible commands are a fill read, a read that takes ownership, an invalidate-only upgrade, or a write-back of dirty data.

A line is in one of three states. Modified means this cache holds the only copy and that copy is dirty. Shared means the copy is clean and other caches may hold it too. Invalid means the line is not present. Across all caches a line is either Modified in exactly one of them or Shared in any number. The block keeps that rule by downgrading or invalidating its own copy when it snoops another cache's read or ownership request. When the snooped line is dirty, the block queues a write-back. Queued write-backs always go out on the bus before any local command. Another agent grants the bus through a request/grant pair, and a command counts as issued in the cycle where request and grant are both high. Data storage and arbitration between caches are handled elsewhere.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, so a snoop to any address gives no response and a processor read needs a bus fill.
- R2: A processor read that finds its line Invalid raises `bus_req` with command code 0 (fill read) and the line address. In the cycle `bus_gnt` is also high, the request completes and the line becomes Shared.
- R3: A processor read that finds its line Shared or Modified completes in the same cycle, makes no bus request and leaves the state unchanged.
- R4: A processor write that finds its line Invalid issues command code 1 (read for ownership) and leaves the line Modified.
- R5: A processor write to a Shared line issues command code 2 (invalidate upgrade) and leaves it Modified. A write to a Modified line completes at once with no bus request.
- R6: A snooped code 0 that hits a Modified line gives `snoop_hit` and `snoop_dirty` in the same cycle and leaves the line Shared. On the next cycle `bus_req` is high with command code 3 (write-back) for that line.
- R7: A snooped code 1 or code 2 that hits a line invalidates it. If the line was Modified, `snoop_dirty` is raised and a code 3 write-back for it follows.
- R8: A snoop that misses on the tag, finds the line Invalid, or carries code 3 gives no response and changes no state.
- R9: In a cycle with `snoop_valid` high, no local bus command is requested and no processor request completes. While a write-back is queued, it is the only command requested.
- R10: A processor miss whose line slot holds a different tag in the Modified state first evicts that line: it queues a write-back of the old line address and marks the slot Invalid. The slot is then filled as in R2 or R4.
- R11: `cpu_busy` is high for every cycle of an outstanding request except its completion cycle. `cpu_done` is high only in the completion cycle.
- R12: Address bits below the line size are ignored for lookup, and `bus_addr` carries them as zero. The bits just above them select the slot and the rest form the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present; held until `cpu_done` |
| cpu_req_write | input | 1 | 1 for a store, 0 for a load |
| cpu_req_addr | input | ADDR_W | Processor byte address |
| cpu_busy | output | 1 | Request outstanding and not completing this cycle |
| cpu_done | output | 1 | Request completes this cycle |
| bus_req | output | 1 | Bus command wanted |
| bus_gnt | input | 1 | Bus granted; the command is issued when both are high |
| bus_cmd | output | 2 | 0 read, 1 read for ownership, 2 upgrade, 3 write-back |
| bus_addr | output | ADDR_W | Line-aligned command address |
| snoop_valid | input | 1 | Another cache's transaction is observed |
| snoop_cmd | input | 2 | Snooped command, same coding as `bus_cmd` |
| snoop_addr | input | ADDR_W | Snooped byte address |
| snoop_hit | output | 1 | The snoop found a valid copy here |
| snoop_dirty | output | 1 | The copy found was Modified; a write-back is queued |

## Verification
The assertions check on every cycle that a snoop blocks local completion, that a dirty snoop response is followed by a write-back request, that a granted local command completes the request, that busy and done never coincide, that bus addresses are aligned, and that the write-back queue never exceeds the number of lines. The state transitions themselves can only be seen over sequences of requests and snoops: read-then-write upgrades, downgrade followed by a later upgrade, and eviction of a dirty victim before a fill. The bench drives these sequences, directed and random, against its own model of the line states and the write-back order.

// File: rtl/coh_pkg.sv
// Shared types for the coherence line controller.
// Assumes: state and command codes are fixed by the bus protocol and
// must not be reordered.
package coh_pkg;

    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHR = 2'd1,
        LS_MOD = 2'd2
    } line_st_t;

    typedef enum logic [1:0] {
        BC_READ  = 2'd0,
        BC_READX = 2'd1,
        BC_UPGR  = 2'd2,
        BC_WBACK = 2'd3
    } bus_cmd_t;

endpackage

// File: rtl/coh_tag_array.sv
// Direct-mapped tag and state store with two combinational read ports
// (processor side and snoop side) and one synchronous write port.
// Assumes: the caller serialises writers, so one write per cycle suffices.
// Every line state resets to Invalid.
module coh_tag_array
    import coh_pkg::*;
#(
    parameter int LINES = 8,
    parameter int TAG_W = 9,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] a_idx,
    output logic [TAG_W-1:0] a_tag,
    output line_st_t         a_state,
    input  logic [IDX_W-1:0] b_idx,
    output logic [TAG_W-1:0] b_tag,
    output line_st_t         b_state,
    input  logic             we,
    input  logic [IDX_W-1:0] w_idx,
    input  logic [TAG_W-1:0] w_tag,
    input  line_st_t         w_state
);

    logic [TAG_W-1:0] tag_q [LINES];
    line_st_t         st_q  [LINES];

    // Update the addressed line; clear all states on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                tag_q[i] <= '0;
                st_q[i]  <= LS_INV;
            end
        end else begin
            for (int i = 0; i < LINES; i++) begin
                if (we && (w_idx == IDX_W'(i))) begin
                    tag_q[i] <= w_tag;
                    st_q[i]  <= w_state;
                end
            end
        end
    end

    // Processor-side lookup.
    always_comb begin
        a_tag   = tag_q[a_idx];
        a_state = st_q[a_idx];
    end

    // Snoop-side lookup.
    always_comb begin
        b_tag   = tag_q[b_idx];
        b_state = st_q[b_idx];
    end

endmodule

// File: rtl/coh_wb_fifo.sv
// Ordered queue of line addresses that wait for a write-back slot on the bus.
// Assumes: push never happens when full. The controller guarantees this
// because each entry is a distinct line that left the Modified state.
// A pop while empty is ignored.
module coh_wb_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 12,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic             empty,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count
);

    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_pop;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty  = (cnt_q == '0);
    assign do_pop = pop && !empty;
    assign head   = mem_q[rd_q];
    assign count  = cnt_q;

    // Store pushed entries and advance both pointers and the fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            if (push) begin
                mem_q[wr_q] <= push_data;
                wr_q        <= ptr_inc(wr_q);
            end
            if (do_pop) rd_q <= ptr_inc(rd_q);
            cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(do_pop);
        end
    end

endmodule

// File: rtl/coh_snoop_logic.sv
// Snoop-side transition decision for one observed transaction.
// Assumes: 'match' means a tag hit on a non-Invalid line. Write-back
// transactions from others need no action here.
module coh_snoop_logic
    import coh_pkg::*;
(
    input  logic     snoop_valid,
    input  bus_cmd_t snoop_cmd,
    input  logic     match,
    input  line_st_t state,
    output logic     resp_hit,
    output logic     resp_dirty,
    output logic     upd,
    output line_st_t next_state
);

    logic act;

    // Decide response and new state: reads downgrade, ownership requests invalidate.
    always_comb begin
        act        = snoop_valid && (snoop_cmd != BC_WBACK) && match;
        resp_hit   = act;
        resp_dirty = act && (state == LS_MOD);
        upd        = act;
        next_state = (snoop_cmd == BC_READ) ? LS_SHR : LS_INV;
    end

endmodule

// File: rtl/coh_cpu_logic.sv
// Processor-side decision: hit completion, dirty-victim eviction, or a
// bus command with its fill state.
// Assumes: a snoop in the same cycle takes precedence, and local commands
// wait while any write-back is queued.
module coh_cpu_logic
    import coh_pkg::*;
(
    input  logic     req_valid,
    input  logic     req_write,
    input  logic     match,
    input  line_st_t slot_state,
    input  logic     snoop_busy,
    input  logic     wb_pending,
    input  logic     bus_gnt,
    output logic     done,
    output logic     fill,
    output logic     evict,
    output logic     local_req,
    output bus_cmd_t local_cmd,
    output line_st_t fill_state
);

    line_st_t cur;
    logic     need_bus;
    logic     go;

    // Classify the request against the current line state.
    always_comb begin
        cur        = match ? slot_state : LS_INV;
        need_bus   = req_write ? (cur != LS_MOD) : (cur == LS_INV);
        go         = req_valid && !snoop_busy;
        evict      = go && need_bus && !match && (slot_state == LS_MOD);
        local_req  = go && need_bus && !evict && !wb_pending;
        fill       = local_req && bus_gnt;
        done       = (go && !need_bus) || fill;
        fill_state = req_write ? LS_MOD : LS_SHR;
        if (!req_write)          local_cmd = BC_READ;
        else if (cur == LS_SHR)  local_cmd = BC_UPGR;
        else                     local_cmd = BC_READX;
    end

endmodule

// File: rtl/coh_line_ctrl.sv
// Three-state snooping coherence controller for one private cache.
// Combines the tag/state store, snoop and processor decisions, and the
// write-back queue, and drives the single-command bus port.
// Assumes: the processor holds its request until cpu_done, and bus_gnt is
// valid in the cycle it answers bus_req.
module coh_line_ctrl
    import coh_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int LINES      = 8,
    parameter int LINE_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    output logic              cpu_busy,
    output logic              cpu_done,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              snoop_valid,
    input  logic [1:0]        snoop_cmd,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              snoop_hit,
    output logic              snoop_dirty
);

    localparam int OFS_W = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W - OFS_W;
    localparam int LN_W  = TAG_W + IDX_W;
    localparam int CNT_W = $clog2(LINES + 1);

    logic [IDX_W-1:0] c_idx, s_idx, w_idx;
    logic [TAG_W-1:0] c_tag, s_tag, a_tag, b_tag, w_tag;
    line_st_t         a_state, b_state, w_state, s_next, fill_st;
    logic             c_match, s_match, we;
    logic             s_upd, ev, fill, loc_req;
    bus_cmd_t         loc_cmd;
    logic             wb_empty, wb_push;
    logic [LN_W-1:0]  wb_head, wb_data;
    logic [CNT_W-1:0] wb_count;
    logic             unused_ofs;

    // Split both request addresses into tag and slot index.
    always_comb begin
        c_idx = cpu_req_addr[OFS_W +: IDX_W];
        c_tag = cpu_req_addr[ADDR_W-1 -: TAG_W];
        s_idx = snoop_addr[OFS_W +: IDX_W];
        s_tag = snoop_addr[ADDR_W-1 -: TAG_W];
    end

    assign unused_ofs = ^{cpu_req_addr[OFS_W-1:0], snoop_addr[OFS_W-1:0]};

    coh_tag_array #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_idx   (c_idx),
        .a_tag   (a_tag),
        .a_state (a_state),
        .b_idx   (s_idx),
        .b_tag   (b_tag),
        .b_state (b_state),
        .we      (we),
        .w_idx   (w_idx),
        .w_tag   (w_tag),
        .w_state (w_state)
    );

    // Tag comparison for both lookups; an Invalid line never matches.
    always_comb begin
        c_match = (a_state != LS_INV) && (a_tag == c_tag);
        s_match = (b_state != LS_INV) && (b_tag == s_tag);
    end

    coh_snoop_logic u_snoop (
        .snoop_valid (snoop_valid),
        .snoop_cmd   (bus_cmd_t'(snoop_cmd)),
        .match       (s_match),
        .state       (b_state),
        .resp_hit    (snoop_hit),
        .resp_dirty  (snoop_dirty),
        .upd         (s_upd),
        .next_state  (s_next)
    );

    coh_cpu_logic u_cpu (
        .req_valid  (cpu_req_valid),
        .req_write  (cpu_req_write),
        .match      (c_match),
        .slot_state (a_state),
        .snoop_busy (snoop_valid),
        .wb_pending (!wb_empty),
        .bus_gnt    (bus_gnt),
        .done       (cpu_done),
        .fill       (fill),
        .evict      (ev),
        .local_req  (loc_req),
        .local_cmd  (loc_cmd),
        .fill_state (fill_st)
    );

    assign cpu_busy = cpu_req_valid && !cpu_done;

    // Single write port: snoop update, then eviction, then fill.
    always_comb begin
        we      = 1'b0;
        w_idx   = c_idx;
        w_tag   = c_tag;
        w_state = LS_INV;
        if (s_upd) begin
            we      = 1'b1;
            w_idx   = s_idx;
            w_tag   = s_tag;
            w_state = s_next;
        end else if (ev) begin
            we      = 1'b1;
            w_tag   = a_tag;
            w_state = LS_INV;
        end else if (fill) begin
            we      = 1'b1;
            w_state = fill_st;
        end
    end

    // Queue write-backs from dirty snoop hits and dirty evictions.
    always_comb begin
        wb_push = snoop_dirty || ev;
        wb_data = snoop_dirty ? {s_tag, s_idx} : {a_tag, c_idx};
    end

    coh_wb_fifo #(.DEPTH(LINES), .W(LN_W)) u_wbq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wb_push),
        .push_data (wb_data),
        .pop       (bus_gnt),
        .empty     (wb_empty),
        .head      (wb_head),
        .count     (wb_count)
    );

    // Bus command select: queued write-backs before local commands.
    always_comb begin
        bus_req = !wb_empty || loc_req;
        if (!wb_empty) begin
            bus_cmd  = 2'(BC_WBACK);
            bus_addr = {wb_head, {OFS_W{1'b0}}};
        end else begin
            bus_cmd  = 2'(loc_cmd);
            bus_addr = {c_tag, c_idx, {OFS_W{1'b0}}};
        end
    end

endmodule

// File: rtl/coh_line_ctrl_chk.sv
// Property checker for coh_line_ctrl, attached with bind.
// Assumes: visibility of the write-back queue fill level only.
module coh_line_ctrl_chk #(
    parameter int ADDR_W     = 16,
    parameter int LINES      = 8,
    parameter int LINE_BYTES = 16,
    localparam int OFS_W = $clog2(LINE_BYTES),
    localparam int CNT_W = $clog2(LINES + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req_valid,
    input logic              cpu_busy,
    input logic              cpu_done,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic [1:0]        bus_cmd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              snoop_valid,
    input logic              snoop_hit,
    input logic              snoop_dirty,
    input logic [CNT_W-1:0]  wb_count
);

    assert_snoop_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_valid |-> !cpu_done);

    assert_wb_after_dirty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_dirty |=> (bus_req && bus_cmd == 2'd3));

    assert_grant_completes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && bus_cmd != 2'd3) |-> cpu_done);

    assert_busy_done_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_busy || cpu_done) |-> (cpu_req_valid && !(cpu_busy && cpu_done)));

    assert_line_aligned_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_addr[OFS_W-1:0] == '0));

    assert_dirty_needs_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_dirty |-> snoop_hit);

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wb_count <= CNT_W'(LINES));

endmodule

bind coh_line_ctrl coh_line_ctrl_chk #(
    .ADDR_W(ADDR_W), .LINES(LINES), .LINE_BYTES(LINE_BYTES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req_valid (cpu_req_valid),
    .cpu_busy      (cpu_busy),
    .cpu_done      (cpu_done),
    .bus_req       (bus_req),
    .bus_gnt       (bus_gnt),
    .bus_cmd       (bus_cmd),
    .bus_addr      (bus_addr),
    .snoop_valid   (snoop_valid),
    .snoop_hit     (snoop_hit),
    .snoop_dirty   (snoop_dirty),
    .wb_count      (wb_count)
);

// File: tb/sim_coh_line_ctrl.sv
`timescale 1ns/1ps
module sim_coh_line_ctrl;

    localparam int ADDR_W = 16;
    localparam int LINES  = 8;
    localparam logic [1:0] RD = 2'd0, RX = 2'd1, UP = 2'd2, WB = 2'd3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
    logic [ADDR_W-1:0] cpu_req_addr = '0;
    logic cpu_busy, cpu_done, bus_req;
    logic bus_gnt = 1'b0;
    logic [1:0] bus_cmd;
    logic [ADDR_W-1:0] bus_addr;
    logic snoop_valid = 1'b0;
    logic [1:0] snoop_cmd = '0;
    logic [ADDR_W-1:0] snoop_addr = '0;
    logic snoop_hit, snoop_dirty;

    int checks = 0;
    int errors = 0;
    int m_st [LINES];
    int m_tg [LINES];
    int wbq [$];

    always #2 clk = ~clk;

    coh_line_ctrl #(.ADDR_W(ADDR_W), .LINES(LINES), .LINE_BYTES(16)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
        .cpu_req_addr(cpu_req_addr), .cpu_busy(cpu_busy), .cpu_done(cpu_done),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .snoop_valid(snoop_valid), .snoop_cmd(snoop_cmd), .snoop_addr(snoop_addr),
        .snoop_hit(snoop_hit), .snoop_dirty(snoop_dirty)
    );

    function automatic logic [15:0] mk(input int tag, input int idx, input int ofs);
        return {9'(tag), 3'(idx), 4'(ofs)};
    endfunction

    task automatic chk(input string ctx, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", ctx, what, act, exp);
        end
    endtask

    // One cycle: drive after a falling edge, compare against the model, advance.
    task automatic cyc(input string ctx, input bit cv, input bit cw, input logic [15:0] ca,
                       input bit sv, input logic [1:0] sc, input logic [15:0] sa,
                       input bit g, output bit done_o);
        int ci, ct, si, stg, cur, vic;
        bit cm, sm, sact, e_sd, need, go, ev, wbne, loc, e_done, e_br;
        int e_cmd, e_ad;
        cpu_req_valid = cv; cpu_req_write = cw; cpu_req_addr = ca;
        snoop_valid = sv; snoop_cmd = sc; snoop_addr = sa; bus_gnt = g;
        #1;
        ci = int'(ca[6:4]); ct = int'(ca[15:7]);
        si = int'(sa[6:4]); stg = int'(sa[15:7]);
        cm   = (m_st[ci] != 0) && (m_tg[ci] == ct);
        cur  = cm ? m_st[ci] : 0;
        vic  = m_tg[ci];
        sm   = (m_st[si] != 0) && (m_tg[si] == stg);
        sact = sv && (sc != WB) && sm;
        e_sd = sact && (m_st[si] == 2);
        need = cv && (cw ? (cur != 2) : (cur == 0));
        go   = cv && !sv;
        ev   = go && need && !cm && (m_st[ci] == 2);
        wbne = (wbq.size() != 0);
        loc  = go && need && !ev && !wbne;
        e_done = (go && !need) || (loc && g);
        e_br   = wbne || loc;
        e_cmd  = wbne ? 3 : (!cw ? 0 : (cur == 1 ? 2 : 1));
        e_ad   = wbne ? (wbq[0] << 4) : int'({ca[15:4], 4'h0});
        chk(ctx, "cpu_done", int'(cpu_done), int'(e_done));
        chk(ctx, "cpu_busy", int'(cpu_busy), int'(cv && !e_done));
        chk(ctx, "bus_req", int'(bus_req), int'(e_br));
        chk(ctx, "snoop_hit", int'(snoop_hit), int'(sact));
        chk(ctx, "snoop_dirty", int'(snoop_dirty), int'(e_sd));
        if (e_br) begin
            chk(ctx, "bus_cmd", int'(bus_cmd), e_cmd);
            chk(ctx, "bus_addr", int'(bus_addr), e_ad);
        end
        done_o = e_done;
        @(posedge clk);
        if (wbne && g) void'(wbq.pop_front());
        if (sact) begin
            if (e_sd) wbq.push_back((stg << 3) | si);
            m_st[si] = (sc == RD) ? 1 : 0;
        end else if (ev) begin
            wbq.push_back((vic << 3) | ci);
            m_st[ci] = 0;
        end else if (loc && g) begin
            m_tg[ci] = ct;
            m_st[ci] = cw ? 2 : 1;
        end
        @(negedge clk);
    endtask

    initial begin : watchdog
        #800000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        bit d;
        bit p_v, p_w;
        logic [15:0] p_a;
        logic [15:0] A, B, C, E;
        A = mk(5, 1, 0); B = mk(6, 2, 3); C = mk(7, 3, 0); E = mk(1, 3, 5);
        for (int i = 0; i < LINES; i++) begin m_st[i] = 0; m_tg[i] = 0; end
        repeat (3) @(negedge clk);
        // Reset state: outputs quiet while reset is held (R1).
        chk("R1 in reset", "bus_req", int'(bus_req), 0);
        chk("R1 in reset", "cpu_busy", int'(cpu_busy), 0);
        rst_n = 1'b1;
        cyc("R1 snoop after reset", 0, 0, 0, 1, RD, A, 0, d);
        cyc("R1 read needs fill", 1, 0, A, 0, RD, 0, 0, d);
        cyc("R11 busy while waiting", 1, 0, A, 0, RD, 0, 0, d);
        cyc("R2 fill granted", 1, 0, A, 0, RD, 0, 1, d);
        cyc("R3 read hit shared", 1, 0, A | 16'h7, 0, RD, 0, 0, d);
        cyc("R5 upgrade request", 1, 1, A, 0, RD, 0, 0, d);
        cyc("R5 upgrade granted", 1, 1, A, 0, RD, 0, 1, d);
        cyc("R5 write hit modified", 1, 1, A, 0, RD, 0, 0, d);
        cyc("R3 read hit modified", 1, 0, A, 0, RD, 0, 0, d);
        cyc("R6 snoop read dirty", 1, 0, B, 1, RD, A, 0, d);
        cyc("R9 write-back before local", 1, 0, B, 0, RD, 0, 0, d);
        cyc("R6 write-back granted", 1, 0, B, 0, RD, 0, 1, d);
        cyc("R2 fill of B", 1, 0, B, 0, RD, 0, 1, d);
        cyc("R6 downgraded clean", 0, 0, 0, 1, RD, A, 0, d);
        cyc("R6 shared needs upgrade", 1, 1, A, 0, RD, 0, 1, d);
        cyc("R7 ownership snoop dirty", 0, 0, 0, 1, RX, A, 0, d);
        cyc("R7 write-back issued", 0, 0, 0, 0, RD, 0, 1, d);
        cyc("R7 line now invalid", 0, 0, 0, 1, RD, A, 0, d);
        cyc("R7 upgrade snoop on shared", 0, 0, 0, 1, UP, B, 0, d);
        cyc("R7 shared invalidated", 0, 0, 0, 1, RD, B, 0, d);
        cyc("R4 write miss ownership", 1, 1, C, 0, RD, 0, 0, d);
        cyc("R4 ownership granted", 1, 1, C, 0, RD, 0, 1, d);
        cyc("R8 write-back snoop ignored", 0, 0, 0, 1, WB, C, 0, d);
        cyc("R8 tag miss ignored", 0, 0, 0, 1, RX, mk(8, 3, 0), 0, d);
        cyc("R8 state kept modified", 1, 1, C, 0, RD, 0, 0, d);
        cyc("R9 snoop stalls local", 1, 0, mk(9, 4, 0), 1, RD, mk(2, 6, 0), 1, d);
        cyc("R10 evict dirty victim", 1, 0, E, 0, RD, 0, 1, d);
        cyc("R10 victim write-back", 1, 0, E, 0, RD, 0, 1, d);
        cyc("R10 fill after eviction", 1, 0, E, 0, RD, 0, 1, d);
        cyc("R12 offset ignored", 1, 0, mk(9, 4, 15), 0, RD, 0, 1, d);
        cyc("R12 hit with other offset", 1, 0, mk(9, 4, 2), 0, RD, 0, 0, d);
        // Random mix of requests, snoops and grants.
        void'($urandom(32'd2024));
        p_v = 0; p_w = 0; p_a = '0;
        for (int n = 0; n < 4000; n++) begin
            bit sv;
            logic [1:0] sc;
            logic [15:0] sa;
            if (!p_v && ($urandom % 3 == 0)) begin
                p_v = 1;
                p_w = 1'($urandom % 2);
                p_a = mk(1 + ($urandom % 3), $urandom % 8, $urandom % 16);
            end
            sv = ($urandom % 4 == 0);
            sc = 2'($urandom % 4);
            sa = mk(1 + ($urandom % 3), $urandom % 8, $urandom % 16);
            cyc("R9 random mix", p_v, p_w, p_a, sv, sc, sa, 1'($urandom % 2), d);
            if (d) p_v = 0;
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule